// File: doc/BRIEF.md
# Two-Tier Round-Based DMA Channel Scheduler

This block picks, once per clock, which of several DMA channels may issue its next bus transfer. A channel can compete only when it is switched on, has an active transfer sequence, and sees the pacing signal it has chosen. Each channel chooses that pacing signal with a 6-bit selector. The selector can name one of the external data-request lines, one of four timer pacing inputs, or an always-asserted request for unpaced copies.

Channels are split into an urgent tier and a normal tier by a per-channel flag. Scheduling proceeds in rounds. In each round, every eligible urgent channel is served once. After that, exactly one eligible normal channel is served, and then the next round begins. Inside each tier the choice rotates, starting just after the channel that tier served last. When no urgent channel is eligible, the normal slot is given at once, so normal channels lose no throughput while the scheduler has spare capacity. The result is a registered one-hot grant and a valid flag. A downstream bus engine uses them to launch the transfer.

Top module: `dma_round_sched`

## Requirements
- R1: After reset, `grant` is all zeros and `grant_valid` is 0.
- R2: A selector value s from 0 to 58 makes channel eligibility follow `dreq[s]`.
- R3: Selector values 59, 60, 61 and 62 select `timer_pace[0]` to `timer_pace[3]`. Value 63 is a request that is always asserted.
- R4: A channel is eligible only when its `ch_enable` bit is 1, its `ch_busy` bit is 1, and its selected pacing signal is 1. A channel that is not eligible is never granted.
- R5: At most one bit of `grant` is set. `grant_valid` is 1 exactly when a bit of `grant` is set.
- R6: Within a round, each eligible urgent channel (`ch_high` bit 1) is granted once. Then one eligible normal channel is granted, and the next round starts with the urgent channels.
- R7: Within each tier, the choice is round-robin in increasing channel index, starting after the channel that tier granted last. After reset, both tiers start their search at channel 0.
- R8: When no urgent channel is eligible, an eligible normal channel is granted in that same decision.
- R9: When no channel is eligible, `grant_valid` is 0 and `grant` is all zeros.
- R10: `grant` and `grant_valid` are registered. They reflect the inputs that were present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_busy | input | NUM_CH | Per-channel sequence-active flag |
| ch_high | input | NUM_CH | Per-channel urgent-tier flag |
| ch_sel | input | NUM_CH*6 | Pacing selectors; channel i uses bits [6i+5:6i] |
| dreq | input | 59 | External data-request lines |
| timer_pace | input | 4 | Timer pacing inputs |
| grant | output | NUM_CH | One-hot grant |
| grant_valid | output | 1 | A grant is asserted |

## Verification
The bench builds the block with four channels. That size is small enough to walk through every selector code against two complementary request patterns, and to run every urgent/normal split through full rounds. A long pseudo-random run then mixes enables, busy flags, tiers and pacing codes, and compares every cycle against a round model written from the requirements. Fixed expected grant sequences pin down the round order and the rotation after reset.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int SEL_W       = 6;
  localparam int NUM_DREQ    = 59;
  localparam int NUM_TIMERS  = 4;
  localparam int PACE_W      = NUM_DREQ + NUM_TIMERS + 1;
  localparam logic [SEL_W-1:0] CODE_TIMER0 = 6'd59;
  localparam logic [SEL_W-1:0] CODE_ALWAYS = 6'd63;

  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_URGENT  = 2'd1,
    PICK_NORMAL  = 2'd2,
    PICK_RESTART = 2'd3
  } pick_kind_e;
endpackage

// File: rtl/dma_pace_select.sv
module dma_pace_select
  import dma_sched_pkg::*;
(
  input  logic [SEL_W-1:0]      sel,
  input  logic [NUM_DREQ-1:0]   dreq,
  input  logic [NUM_TIMERS-1:0] timer_pace,
  output logic                  pace
);
  // Code space: data-request lines, then timers, then the always-on request.
  logic [PACE_W-1:0] pace_vec;
  assign pace_vec = {1'b1, timer_pace, dreq};
  assign pace     = pace_vec[sel];
endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = last;
    any = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int c;
      c = (int'(last) + off) % N;
      if (!any && req[c]) begin
        any    = 1'b1;
        gnt[c] = 1'b1;
        idx    = IW'(c);
      end
    end
  end
endmodule

// File: rtl/dma_round_sched.sv
module dma_round_sched
  import dma_sched_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         ch_enable,
  input  logic [NUM_CH-1:0]         ch_busy,
  input  logic [NUM_CH-1:0]         ch_high,
  input  logic [NUM_CH*SEL_W-1:0]   ch_sel,
  input  logic [NUM_DREQ-1:0]       dreq,
  input  logic [NUM_TIMERS-1:0]     timer_pace,
  output logic [NUM_CH-1:0]         grant,
  output logic                      grant_valid
);
  logic [NUM_CH-1:0] pace;
  logic [NUM_CH-1:0] ready;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_pace
    dma_pace_select u_pace (
      .sel        (ch_sel[i*SEL_W +: SEL_W]),
      .dreq       (dreq),
      .timer_pace (timer_pace),
      .pace       (pace[i])
    );
  end

  assign ready = ch_enable & ch_busy & pace;

  // Round state: urgent channels already served this round, per-tier pointers.
  logic [NUM_CH-1:0] served_q, served_d;
  logic [IW-1:0]     urg_last_q, urg_last_d;
  logic [IW-1:0]     nrm_last_q, nrm_last_d;
  logic [NUM_CH-1:0] grant_d;
  logic              valid_d;
  pick_kind_e        kind;

  logic [NUM_CH-1:0] urg_fresh, urg_all, nrm_req, urg_req;
  assign urg_all   = ready & ch_high;
  assign urg_fresh = urg_all & ~served_q;
  assign nrm_req   = ready & ~ch_high;
  assign urg_req   = (|urg_fresh) ? urg_fresh : urg_all;

  logic [NUM_CH-1:0] urg_gnt, nrm_gnt;
  logic [IW-1:0]     urg_idx, nrm_idx;
  logic              urg_any, nrm_any;

  dma_rr_pick #(.N(NUM_CH)) u_urg (
    .req (urg_req), .last (urg_last_q),
    .gnt (urg_gnt), .idx (urg_idx), .any (urg_any)
  );

  dma_rr_pick #(.N(NUM_CH)) u_nrm (
    .req (nrm_req), .last (nrm_last_q),
    .gnt (nrm_gnt), .idx (nrm_idx), .any (nrm_any)
  );

  always_comb begin
    if (|urg_fresh)   kind = PICK_URGENT;
    else if (nrm_any) kind = PICK_NORMAL;
    else if (urg_any) kind = PICK_RESTART;
    else              kind = PICK_NONE;
  end

  always_comb begin
    served_d   = served_q;
    urg_last_d = urg_last_q;
    nrm_last_d = nrm_last_q;
    grant_d    = '0;
    valid_d    = 1'b0;
    unique case (kind)
      PICK_URGENT: begin
        grant_d    = urg_gnt;
        valid_d    = 1'b1;
        served_d   = served_q | urg_gnt;
        urg_last_d = urg_idx;
      end
      PICK_NORMAL: begin
        grant_d    = nrm_gnt;
        valid_d    = 1'b1;
        served_d   = '0;
        nrm_last_d = nrm_idx;
      end
      PICK_RESTART: begin
        grant_d    = urg_gnt;
        valid_d    = 1'b1;
        served_d   = urg_gnt;
        urg_last_d = urg_idx;
      end
      default: ;
    endcase
  end

  // Round state advances only when a grant is issued.
  logic state_en;
  assign state_en = (kind != PICK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
    end else begin
      grant       <= grant_d;
      grant_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served_q   <= '0;
      urg_last_q <= IW'(NUM_CH - 1);
      nrm_last_q <= IW'(NUM_CH - 1);
    end else if (state_en) begin
      served_q   <= served_d;
      urg_last_q <= urg_last_d;
      nrm_last_q <= nrm_last_d;
    end
  end
endmodule

// File: rtl/dma_round_sched_sva.sv
module dma_round_sched_sva
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       ch_enable,
  input logic [NUM_CH-1:0]       ch_busy,
  input logic [NUM_CH*SEL_W-1:0] ch_sel,
  input logic [NUM_CH-1:0]       grant,
  input logic                    grant_valid
);
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r5_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  a_r4_granted_was_active: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((grant & $past(ch_enable) & $past(ch_busy)) == grant));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_enable & ch_busy) == '0) |=> !grant_valid);

  a_r3_permanent: assert property (@(posedge clk) disable iff (!rst_n)
    (((ch_enable & ch_busy) == NUM_CH'(1)) && (ch_sel[SEL_W-1:0] == CODE_ALWAYS))
      |=> (grant == NUM_CH'(1)));
endmodule

bind dma_round_sched dma_round_sched_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_enable   (ch_enable),
  .ch_busy     (ch_busy),
  .ch_sel      (ch_sel),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/sim_dma_round_sched.sv
module sim_dma_round_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] ch_enable, ch_busy, ch_high;
  logic [NC*6-1:0] ch_sel;
  logic [58:0]   dreq;
  logic [3:0]    timer_pace;
  logic [NC-1:0] grant;
  logic          grant_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_round_sched #(.NUM_CH(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_busy(ch_busy),
    .ch_high(ch_high), .ch_sel(ch_sel), .dreq(dreq), .timer_pace(timer_pace),
    .grant(grant), .grant_valid(grant_valid)
  );

  // Reference round model built from the requirements.
  logic [NC-1:0] m_served;
  int            m_ulast, m_nlast;

  function automatic logic m_pace(input logic [5:0] s);
    if (s < 6'd59)      return dreq[s];
    else if (s < 6'd63) return timer_pace[s - 6'd59];
    else                return 1'b1;
  endfunction

  function automatic int m_rr(input logic [NC-1:0] req, input int last);
    for (int k = 1; k <= NC; k++) begin
      int c;
      c = (last + k) % NC;
      if (req[c]) return c;
    end
    return -1;
  endfunction

  task automatic m_reset();
    m_served = '0; m_ulast = NC - 1; m_nlast = NC - 1;
  endtask

  task automatic m_step(output logic [NC-1:0] eg);
    logic [NC-1:0] rdy, fresh, uall, nrm;
    int c;
    for (int i = 0; i < NC; i++)
      rdy[i] = ch_enable[i] & ch_busy[i] & m_pace(ch_sel[i*6 +: 6]);
    uall  = rdy & ch_high;
    fresh = uall & ~m_served;
    nrm   = rdy & ~ch_high;
    eg = '0;
    if (fresh != 0) begin
      c = m_rr(fresh, m_ulast); eg[c] = 1'b1; m_served[c] = 1'b1; m_ulast = c;
    end else if (nrm != 0) begin
      c = m_rr(nrm, m_nlast); eg[c] = 1'b1; m_served = '0; m_nlast = c;
    end else if (uall != 0) begin
      c = m_rr(uall, m_ulast); eg[c] = 1'b1; m_served = eg; m_ulast = c;
    end
  endtask

  task automatic chk(input string req, input logic [NC-1:0] eg);
    checks++;
    if (grant !== eg || grant_valid !== (eg != 0)) begin
      errors++;
      $display("FAIL %s grant=%b valid=%b expected grant=%b valid=%b",
               req, grant, grant_valid, eg, (eg != 0));
    end
  endtask

  // Called at a negedge with inputs already set: advance one edge and compare.
  task automatic step(input string req);
    logic [NC-1:0] eg;
    m_step(eg);
    @(negedge clk);
    chk(req, eg);
  endtask

  task automatic do_reset();
    ch_enable = '0; ch_busy = '0; ch_high = '0; ch_sel = '0;
    dreq = '0; timer_pace = '0;
    rst_n = 1'b0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [NC-1:0] seq [9];
    do_reset();
    // R1: reset state
    chk("R1", '0);

    // R6/R7: urgent {0,2}, normal {1,3}, all always-request
    ch_enable = '1; ch_busy = '1; ch_high = 4'b0101;
    ch_sel = {4{6'd63}};
    seq = '{4'b0001, 4'b0100, 4'b0010, 4'b0001, 4'b0100,
            4'b1000, 4'b0001, 4'b0100, 4'b0010};
    for (int k = 0; k < 9; k++) begin
      logic [NC-1:0] eg;
      m_step(eg);
      @(negedge clk);
      chk("R6", seq[k]);
    end

    // R8/R7: no urgent channel, normal tier rotates from channel 0
    do_reset();
    ch_enable = '1; ch_busy = '1; ch_high = '0; ch_sel = {4{6'd63}};
    seq = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0001,
            4'b0010, 4'b0100, 4'b1000, 4'b0001};
    for (int k = 0; k < 9; k++) begin
      logic [NC-1:0] eg;
      m_step(eg);
      @(negedge clk);
      chk("R8", seq[k]);
    end

    // R9: nothing eligible
    ch_enable = '0;
    step("R9");
    ch_enable = '1; ch_busy = '0;
    step("R9");

    // R2/R3: sweep every selector code on channel 0 with two request patterns
    ch_enable = 4'b0001; ch_busy = 4'b0001; ch_high = 4'b0001;
    for (int p = 0; p < 2; p++) begin
      dreq       = p ? {30{2'b10}} : {30{2'b01}};
      timer_pace = p ? 4'b1010 : 4'b0101;
      for (int s = 0; s < 64; s++) begin
        ch_sel = {18'd0, 6'(s)};
        step(s < 59 ? "R2" : "R3");
      end
    end

    // R4/R10: enable or busy alone is not enough
    ch_sel = {4{6'd63}}; ch_enable = 4'b0011; ch_busy = 4'b1100; ch_high = 4'b0000;
    step("R4");

    // R6/R7: every tier split, permanent requests, full rounds
    do_reset();
    ch_enable = '1; ch_busy = '1; ch_sel = {4{6'd63}};
    for (int h = 0; h < 16; h++) begin
      ch_high = 4'(h);
      for (int k = 0; k < 12; k++) step("R7");
    end

    // R4/R5/R6/R10: pseudo-random mix against the round model
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      for (int j = 0; j < 6; j++) lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]};
      ch_enable  = lfsr[3:0] | 4'b0101;
      ch_busy    = lfsr[7:4] | 4'b1010;
      ch_high    = lfsr[11:8];
      timer_pace = lfsr[15:12];
      dreq       = {15{lfsr[3:0]}};
      for (int i = 0; i < NC; i++) begin
        logic [2:0] r;
        r = 3'(lfsr >> (i * 3));
        ch_sel[i*6 +: 6] = r[2] ? (6'd59 + 6'(r[1:0])) :
                           (r[1:0] == 2'd3 ? 6'd63 : 6'(r[1:0]));
      end
      step("R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule